// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block steers instruction flow in a small 8-bit processor with a 16-bit address space. The program counter is kept as two byte-wide halves. The block walks it through each instruction's opcode and operand bytes on a byte-wide memory port. It carries out the flow-changing operations: absolute jump, branch on zero, branch on carry, halt, subroutine call and return. It also handles pushing and popping the accumulator on a fixed 256-byte stack.

While the block presents an opcode byte on the memory port, an external decoder turns that byte into an operation code, and the block samples it in the same cycle. The zero and carry flags come from outside. The accumulator value to push comes in on its own port. A popped byte goes out with a one-cycle write strobe.

After reset the machine sits paused. A rising edge on the run control switches free-running mode on or off. While paused, each rising edge on the step control advances exactly one machine cycle.

Top module: `pc_stack_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a run or step edge arrives, `mem_addr` is 0xFFFC. In that time neither `mem_we` nor `acc_wr` is asserted.
- R2: While paused, each rising edge of `step` advances exactly one machine cycle. Between edges `mem_addr` stays unchanged and nothing is written.
- R3: Each rising edge of `run_toggle` switches free-running on or off. Turning it off freezes `mem_addr`.
- R4: The operation code is sampled while the opcode byte is on `mem_rdata`, and the program counter steps by one for every byte consumed. The codes are: 0 no operand, 1 one operand byte, 2 two operand bytes, 3 jump, 4 branch if zero, 5 branch if carry, 6 halt, 7 call, 8 return, 9 push, 10 pop. Unused codes act as code 0.
- R5: Jump (3) reads a two-byte target, low byte first, and continues from that target.
- R6: Branch if zero (4) goes to its target only when `zero` is 1. Otherwise it continues after the operand.
- R7: Branch if carry (5) goes to its target only when `carry` is 1. Otherwise it continues after the operand.
- R8: After halt (6), `mem_addr` holds the address after the halt byte. No further write happens, and `step` and `run_toggle` are ignored until reset.
- R9: The 8-bit stack pointer resets to 0xFF. Push (9) writes `acc_in` at 0x0010 plus the pointer, then decrements the pointer.
- R10: Pop (10) first increments the pointer, then reads 0x0010 plus the pointer and pulses `acc_wr` with that byte on `acc_wdata`. Popping at pointer 0xFF wraps to 0x00 and reads 0x0010.
- R11: Call (7) pushes the address following its operand, high byte first and then low byte, on two consecutive descending stack locations. It then continues at its target.
- R12: Return (8) pops the low byte and then the high byte, and continues at the address they form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_toggle | input | 1 | Rising edge toggles free-running |
| step | input | 1 | Rising edge advances one cycle while paused |
| op_in | input | 4 | Decoded operation for the opcode byte on `mem_rdata` |
| zero | input | 1 | Zero flag |
| carry | input | 1 | Carry flag |
| acc_in | input | 8 | Accumulator value for push |
| mem_rdata | input | 8 | Memory read data, valid for the current `mem_addr` |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| acc_wr | output | 1 | Popped byte strobe for the accumulator |
| acc_wdata | output | 8 | Popped byte |

## Verification
The assertions assume that memory reads are combinational, so `mem_rdata` always reflects the current `mem_addr`. They also assume that `op_in` is a pure function of the byte being read. The bench meets both by modelling memory as a combinational array and deriving `op_in` from the low nibble of `mem_rdata`. The flags are assumed steady over each branch, and the bench holds them constant for a whole run. The program it runs keeps every push matched by a pop, and it only pops an empty stack in the deliberate wrap case.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_OPND1 = 4'd1,
    OP_OPND2 = 4'd2,
    OP_JMP = 4'd3,
    OP_BRZ = 4'd4,
    OP_BRC = 4'd5,
    OP_HALT = 4'd6,
    OP_CALL = 4'd7,
    OP_RET = 4'd8,
    OP_PUSH = 4'd9,
    OP_POP = 4'd10
  } op_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_SKIP_B,
    ST_SKIP_A,
    ST_TGT_LO,
    ST_TGT_HI,
    ST_CALL_H,
    ST_CALL_L,
    ST_RET_L,
    ST_RET_H,
    ST_PUSH,
    ST_POP,
    ST_HALT
  } st_e;
endpackage

// File: rtl/pcs_run_ctrl.sv
module pcs_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_toggle,
  input  logic step,
  input  logic halted,
  output logic rst_sync_n,
  output logic tick_en
);
  logic sync_q1, sync_q2;
  logic run_prev, step_prev, running, running_nxt;
  logic run_rise, step_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= 1'b1;
      sync_q2 <= sync_q1;
    end
  end
  assign rst_sync_n = sync_q2;

  assign run_rise  = run_toggle & ~run_prev;
  assign step_rise = step & ~step_prev;

  always_comb begin
    running_nxt = running;
    if (run_rise) running_nxt = ~running;
    if (halted)   running_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_prev  <= 1'b0;
      step_prev <= 1'b0;
      running   <= 1'b0;
    end else begin
      run_prev  <= run_toggle;
      step_prev <= step;
      running   <= running_nxt;
    end
  end

  assign tick_en = ~halted & (running | step_rise);
endmodule

// File: rtl/pcs_pc_reg.sv
module pcs_pc_reg #(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] RESET_VEC = 16'hFFFC,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              inc,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] pc
);
  logic [DATA_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [DATA_W-1:0] lo_inc;
  logic              lo_wrap;

  assign {lo_wrap, lo_inc} = {1'b0, lo_q} + {{DATA_W{1'b0}}, 1'b1};

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (load) begin
      lo_d = load_val[DATA_W-1:0];
      hi_d = load_val[ADDR_W-1:DATA_W];
    end else if (inc) begin
      lo_d = lo_inc;
      hi_d = hi_q + {{(DATA_W-1){1'b0}}, lo_wrap};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= RESET_VEC[DATA_W-1:0];
      hi_q <= RESET_VEC[ADDR_W-1:DATA_W];
    end else if (en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign pc = {hi_q, lo_q};
endmodule

// File: rtl/pcs_stack_ptr.sv
module pcs_stack_ptr #(
  parameter int SP_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] pop_addr
);
  logic [SP_W-1:0] sp_q, sp_d, sp_up;

  assign sp_up     = sp_q + {{(SP_W-1){1'b0}}, 1'b1};
  assign push_addr = STACK_BASE + {{(ADDR_W-SP_W){1'b0}}, sp_q};
  assign pop_addr  = STACK_BASE + {{(ADDR_W-SP_W){1'b0}}, sp_up};

  always_comb begin
    sp_d = sp_q;
    if (push)     sp_d = sp_q - {{(SP_W-1){1'b0}}, 1'b1};
    else if (pop) sp_d = sp_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sp_q <= {SP_W{1'b1}};
    else if (en) sp_q <= sp_d;
  end
endmodule

// File: rtl/pcs_seq_fsm.sv
module pcs_seq_fsm
  import pcs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [3:0]        op_in,
  input  logic              zero,
  input  logic              carry,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [ADDR_W-1:0] pop_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              acc_wr,
  output logic              pc_inc,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_val,
  output logic              sp_push,
  output logic              sp_pop,
  output logic              halted
);
  st_e               state_q, state_d;
  op_e               op_q, op_now;
  logic [DATA_W-1:0] tgt_lo_q, tgt_hi_q;
  logic              lo_en, hi_en, op_en, we_raw, accw_raw;

  assign op_now = op_e'(op_in);

  always_comb begin
    state_d   = state_q;
    mem_addr  = pc;
    we_raw    = 1'b0;
    mem_wdata = '0;
    accw_raw  = 1'b0;
    pc_inc    = 1'b0;
    pc_load   = 1'b0;
    pc_val    = {mem_rdata, tgt_lo_q};
    sp_push   = 1'b0;
    sp_pop    = 1'b0;
    lo_en     = 1'b0;
    hi_en     = 1'b0;
    op_en     = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        pc_inc = 1'b1;
        op_en  = 1'b1;
        case (op_now)
          OP_OPND1: state_d = ST_SKIP_A;
          OP_OPND2: state_d = ST_SKIP_B;
          OP_JMP, OP_BRZ, OP_BRC, OP_CALL: state_d = ST_TGT_LO;
          OP_HALT:  state_d = ST_HALT;
          OP_RET:   state_d = ST_RET_L;
          OP_PUSH:  state_d = ST_PUSH;
          OP_POP:   state_d = ST_POP;
          default:  state_d = ST_FETCH;
        endcase
      end
      ST_SKIP_B: begin
        pc_inc  = 1'b1;
        state_d = ST_SKIP_A;
      end
      ST_SKIP_A: begin
        pc_inc  = 1'b1;
        state_d = ST_FETCH;
      end
      ST_TGT_LO: begin
        pc_inc  = 1'b1;
        lo_en   = 1'b1;
        state_d = ST_TGT_HI;
      end
      ST_TGT_HI: begin
        state_d = ST_FETCH;
        case (op_q)
          OP_JMP: pc_load = 1'b1;
          OP_BRZ: begin
            pc_load = zero;
            pc_inc  = ~zero;
          end
          OP_BRC: begin
            pc_load = carry;
            pc_inc  = ~carry;
          end
          default: begin
            pc_inc  = 1'b1;
            hi_en   = 1'b1;
            state_d = ST_CALL_H;
          end
        endcase
      end
      ST_CALL_H: begin
        mem_addr  = push_addr;
        we_raw    = 1'b1;
        mem_wdata = pc[ADDR_W-1:DATA_W];
        sp_push   = 1'b1;
        state_d   = ST_CALL_L;
      end
      ST_CALL_L: begin
        mem_addr  = push_addr;
        we_raw    = 1'b1;
        mem_wdata = pc[DATA_W-1:0];
        sp_push   = 1'b1;
        pc_load   = 1'b1;
        pc_val    = {tgt_hi_q, tgt_lo_q};
        state_d   = ST_FETCH;
      end
      ST_RET_L: begin
        mem_addr = pop_addr;
        sp_pop   = 1'b1;
        lo_en    = 1'b1;
        state_d  = ST_RET_H;
      end
      ST_RET_H: begin
        mem_addr = pop_addr;
        sp_pop   = 1'b1;
        pc_load  = 1'b1;
        state_d  = ST_FETCH;
      end
      ST_PUSH: begin
        mem_addr  = push_addr;
        we_raw    = 1'b1;
        mem_wdata = acc_in;
        sp_push   = 1'b1;
        state_d   = ST_FETCH;
      end
      ST_POP: begin
        mem_addr = pop_addr;
        sp_pop   = 1'b1;
        accw_raw = 1'b1;
        state_d  = ST_FETCH;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  assign mem_we = we_raw & en;
  assign acc_wr = accw_raw & en;
  assign halted = (state_q == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_FETCH;
      op_q     <= OP_NONE;
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
    end else if (en) begin
      state_q <= state_d;
      if (op_en) op_q     <= op_now;
      if (lo_en) tgt_lo_q <= mem_rdata;
      if (hi_en) tgt_hi_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq #(
  parameter int DATA_W = 8,
  parameter int SP_W = 8,
  parameter logic [2*DATA_W-1:0] RESET_VEC = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] STACK_BASE = 16'h0010,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_toggle,
  input  logic              step,
  input  logic [3:0]        op_in,
  input  logic              zero,
  input  logic              carry,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              acc_wr,
  output logic [DATA_W-1:0] acc_wdata
);
  logic              rst_sync_n, tick_en, halted;
  logic              pc_inc, pc_load, sp_push, sp_pop;
  logic [ADDR_W-1:0] pc, pc_val, push_addr, pop_addr;

  pcs_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .run_toggle(run_toggle), .step(step),
    .halted(halted), .rst_sync_n(rst_sync_n), .tick_en(tick_en)
  );

  pcs_pc_reg #(.DATA_W(DATA_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk(clk), .rst_n(rst_sync_n), .en(tick_en), .inc(pc_inc),
    .load(pc_load), .load_val(pc_val), .pc(pc)
  );

  pcs_stack_ptr #(.SP_W(SP_W), .ADDR_W(ADDR_W), .STACK_BASE(STACK_BASE)) u_sp (
    .clk(clk), .rst_n(rst_sync_n), .en(tick_en), .push(sp_push),
    .pop(sp_pop), .push_addr(push_addr), .pop_addr(pop_addr)
  );

  pcs_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .en(tick_en), .op_in(op_in),
    .zero(zero), .carry(carry), .mem_rdata(mem_rdata), .acc_in(acc_in),
    .pc(pc), .push_addr(push_addr), .pop_addr(pop_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .acc_wr(acc_wr), .pc_inc(pc_inc), .pc_load(pc_load), .pc_val(pc_val),
    .sp_push(sp_push), .sp_pop(sp_pop), .halted(halted)
  );

  assign acc_wdata = mem_rdata;
endmodule

// File: rtl/pc_stack_seq_chk.sv
module pc_stack_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int SP_W = 8,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              halted,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              acc_wr
);
  localparam logic [ADDR_W-1:0] STK_LAST = STACK_BASE + ADDR_W'((1 << SP_W) - 1);

  logic in_stack;
  assign in_stack = (mem_addr >= STACK_BASE) && (mem_addr <= STK_LAST);

  // R1
  paused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |-> (!mem_we && !acc_wr));

  // R2
  paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(mem_addr));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(mem_addr) && !mem_we));

  // R9
  write_in_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> in_stack);

  // R10
  pop_in_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |-> (in_stack && !mem_we));

  // R11
  call_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));
endmodule

bind pc_stack_seq pc_stack_seq_chk #(
  .ADDR_W(ADDR_W), .SP_W(SP_W), .STACK_BASE(STACK_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick_en(tick_en), .halted(halted),
  .mem_addr(mem_addr), .mem_we(mem_we), .acc_wr(acc_wr)
);

// File: tb/pc_stack_seq_tb.sv
module pc_stack_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n, run_toggle, step, zero, carry;
  logic [7:0]  acc_in, mem_rdata, mem_wdata, acc_wdata;
  logic [3:0]  op_in;
  logic [15:0] mem_addr;
  logic        mem_we, acc_wr;

  logic [7:0]  mem [0:2047];
  logic [15:0] w_addr [0:15];
  logic [7:0]  w_data [0:15];
  logic [15:0] r_addr [0:15];
  logic [7:0]  r_data [0:15];
  int          w_n, r_n;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  function automatic int midx(input logic [15:0] a);
    return {21'd0, a[15], a[9:0]};
  endfunction

  assign mem_rdata = mem[midx(mem_addr)];
  assign op_in     = mem_rdata[3:0];

  pc_stack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .run_toggle(run_toggle), .step(step),
    .op_in(op_in), .zero(zero), .carry(carry), .acc_in(acc_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .acc_wr(acc_wr), .acc_wdata(acc_wdata)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[midx(mem_addr)] <= mem_wdata;
      if (w_n < 16) begin
        w_addr[w_n] <= mem_addr;
        w_data[w_n] <= mem_wdata;
      end
      w_n <= w_n + 1;
    end
    if (acc_wr) begin
      if (r_n < 16) begin
        r_addr[r_n] <= mem_addr;
        r_data[r_n] <= acc_wdata;
      end
      r_n <= r_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    mem[midx(a)] = d;
  endtask

  task automatic load_program;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    put(16'hFFFC, 8'h03); put(16'hFFFD, 8'h00); put(16'hFFFE, 8'h02);
    put(16'h0200, 8'h01); put(16'h0201, 8'hEE);
    put(16'h0202, 8'h02); put(16'h0203, 8'hEE); put(16'h0204, 8'hEE);
    put(16'h0205, 8'h09); put(16'h0206, 8'h0A);
    put(16'h0207, 8'h07); put(16'h0208, 8'h00); put(16'h0209, 8'h03);
    put(16'h020A, 8'h04); put(16'h020B, 8'h80); put(16'h020C, 8'h02);
    put(16'h020D, 8'h05); put(16'h020E, 8'h90); put(16'h020F, 8'h02);
    put(16'h0210, 8'h06);
    put(16'h0300, 8'h09); put(16'h0301, 8'h0A); put(16'h0302, 8'h00);
    put(16'h0303, 8'h08);
    put(16'h0280, 8'h0A);
    put(16'h0281, 8'h05); put(16'h0282, 8'h90); put(16'h0283, 8'h02);
    put(16'h0284, 8'h06);
    put(16'h0290, 8'h06);
    put(16'h0010, 8'hC3);
  endtask

  task automatic do_reset(input logic z, input logic c);
    rst_n = 1'b0; run_toggle = 1'b0; step = 1'b0;
    zero = z; carry = c; acc_in = 8'h5A;
    load_program();
    w_n = 0; r_n = 0;
    repeat (3) @(negedge clk);
    chk(mem_addr == 16'hFFFC, "R1 reset addr", mem_addr, 16'hFFFC);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_run;
    run_toggle = 1'b1; @(negedge clk); run_toggle = 1'b0; @(negedge clk);
  endtask

  task automatic test_reset_and_step;
    do_reset(1'b0, 1'b1);
    chk(mem_addr == 16'hFFFC, "R1 paused addr", mem_addr, 16'hFFFC);
    chk(w_n == 0 && r_n == 0, "R1 no access", w_n + r_n, 0);
    step = 1'b1; @(negedge clk);
    chk(mem_addr == 16'hFFFD, "R2 one step", mem_addr, 16'hFFFD);
    repeat (4) @(negedge clk);
    chk(mem_addr == 16'hFFFD, "R2 held step", mem_addr, 16'hFFFD);
    step = 1'b0; @(negedge clk);
    step = 1'b1; @(negedge clk); step = 1'b0; @(negedge clk);
    chk(mem_addr == 16'hFFFE, "R2 second step R5 target hi", mem_addr, 16'hFFFE);
  endtask

  task automatic test_run_carry;
    pulse_run();
    repeat (200) @(negedge clk);
    chk(mem_addr == 16'h0291, "R7 carry branch taken, R8 halt addr", mem_addr, 16'h0291);
    chk(w_n == 4, "R9 R11 write count", w_n, 4);
    chk(w_addr[0] == 16'h010F && w_data[0] == 8'h5A, "R9 push", w_addr[0], 16'h010F);
    chk(w_addr[1] == 16'h010F && w_data[1] == 8'h02, "R11 call high", w_data[1], 8'h02);
    chk(w_addr[2] == 16'h010E && w_data[2] == 8'h0A, "R11 call low", w_data[2], 8'h0A);
    chk(w_addr[3] == 16'h010D && w_data[3] == 8'h5A, "R11 push in sub", w_addr[3], 16'h010D);
    chk(r_n == 2, "R6 zero branch not taken, R12 return", r_n, 2);
    chk(r_addr[0] == 16'h010F && r_data[0] == 8'h5A, "R10 pop", r_addr[0], 16'h010F);
    chk(r_addr[1] == 16'h010D && r_data[1] == 8'h5A, "R10 pop in sub", r_addr[1], 16'h010D);
  endtask

  task automatic test_halt_ignores;
    int wn0, rn0;
    wn0 = w_n; rn0 = r_n;
    step = 1'b1; @(negedge clk); step = 1'b0; @(negedge clk);
    pulse_run(); pulse_run();
    repeat (10) @(negedge clk);
    chk(mem_addr == 16'h0291, "R8 halt holds", mem_addr, 16'h0291);
    chk(w_n == wn0 && r_n == rn0, "R8 no access", w_n, wn0);
  endtask

  task automatic test_run_zero;
    logic [15:0] frz;
    do_reset(1'b1, 1'b0);
    pulse_run();
    @(negedge clk);
    pulse_run();
    frz = mem_addr;
    repeat (6) @(negedge clk);
    chk(mem_addr == frz, "R3 toggle off freezes", mem_addr, frz);
    chk(frz != 16'hFFFC, "R3 toggle on ran", frz, 16'hFFFD);
    pulse_run();
    repeat (200) @(negedge clk);
    chk(mem_addr == 16'h0285, "R6 zero taken, R7 carry not taken, R4", mem_addr, 16'h0285);
    chk(r_n == 3, "R12 return path pop count", r_n, 3);
    chk(r_addr[2] == 16'h0010 && r_data[2] == 8'hC3, "R10 wrap pop", r_addr[2], 16'h0010);
  endtask

  initial begin
    test_reset_and_step();
    test_run_carry();
    test_halt_ignores();
    test_run_zero();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule